// File: doc/BRIEF.md
# Data Trace Address Range Qualifier

This block observes a processor's load/store bus and decides, for each sampled access, whether that access should be passed on to a trace message generator. It holds a small bank of range channels, two by default. Each channel has a word start address, a word end address and a two-bit direction enable. A valid bus access is compared against every channel. If any channel accepts it, a registered qualify strobe appears one clock later. The strobe carries the captured address, data and direction, and a per-channel hit vector.

The relative order of a channel's start and end encodes its mode. A start below the end gives an inclusive span. Equal values select one word. A start above the end is an invalid range, which never matches and is flagged on a status pin.

The bus side is a pure observation port. `bus_valid` marks a sampled access, and the block has no ready signal, because a processor bus cannot be stalled by a trace qualifier. The qualified output is likewise a valid-only stream. The consumer must accept a beat on every cycle that `trc_valid` is high, and no back-pressure path exists. Channel configuration uses plain control pins, with one full channel written per cycle.

Top module: `dtq_range_qual`

## Requirements
- R1: After reset every channel has start 0, end 0 and enable 00. `trc_valid`, `trc_hit` and `range_bad` are all 0.
- R2: A cycle with `cfg_we` high loads start, end and enable into channel `cfg_ch`. The new setting governs accesses sampled from the next clock on, and the other channels keep their settings.
- R3: Start and end are word addresses, meaning bits ADDR_W-1:2 of a byte address. Matching uses only `bus_addr[ADDR_W-1:2]`, so the two low access address bits never change a match decision.
- R4: Enable bit 0 traces reads (`bus_write`=0) and enable bit 1 traces writes (`bus_write`=1). Both bits may be set together, and enable 00 never matches.
- R5: When start < end, a channel matches every word address from start through end, with both ends included.
- R6: When start == end, a channel matches only that single word.
- R7: When start > end, a channel never matches. Its `range_bad` bit reads 1 from the clock after the write that made the range invalid.
- R8: An access is qualified if any channel matches it. `trc_hit[i]` is 1 exactly when channel i matched.
- R9: `trc_valid` rises one clock after a sampled access that qualified, and `trc_addr`, `trc_data` and `trc_write` carry that access. It is 0 after a cycle with no qualifying access.
- R10: No address region is treated specially. An access in low memory (0x2000 to 0x3FF0) is traced like any other address when it falls in an active range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one channel's configuration |
| cfg_ch | input | CH_W | Channel index for the write |
| cfg_start_word | input | ADDR_W-2 | Range start word address |
| cfg_end_word | input | ADDR_W-2 | Range end word address |
| cfg_dir_en | input | 2 | Bit 0 traces reads, bit 1 traces writes |
| bus_valid | input | 1 | Bus access sampled this cycle |
| bus_write | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_data | input | DATA_W | Data of the access |
| trc_valid | output | 1 | Qualified access beat |
| trc_addr | output | ADDR_W | Captured byte address |
| trc_data | output | DATA_W | Captured data |
| trc_write | output | 1 | Captured direction |
| trc_hit | output | NCH | Channels that matched |
| range_bad | output | NCH | Channel holds an invalid range |

## Verification
The qualify strobe and its payload are due one clock after the edge that samples the access. The invalid-range flag is due right after the edge that takes the configuration write. The bench drives inputs on falling edges. On each rising edge its reference model decides the expected outputs from the configuration held before that edge, and only then applies any write. It compares on the following falling edge, so a write and an access in the same cycle are checked against the old setting, as the registers require.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
  localparam int DIR_RD_BIT = 0;
  localparam int DIR_WR_BIT = 1;
  typedef logic [1:0] dir_en_t;
endpackage

// File: rtl/dtq_cfg_bank.sv
module dtq_cfg_bank
  import dtq_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int WA_W = 30,
  parameter int CH_W = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CH_W-1:0]            cfg_ch,
  input  logic [WA_W-1:0]            cfg_start_word,
  input  logic [WA_W-1:0]            cfg_end_word,
  input  dir_en_t                    cfg_dir_en,
  output logic [NCH-1:0][WA_W-1:0]   start_q,
  output logic [NCH-1:0][WA_W-1:0]   end_q,
  output logic [NCH-1:0][1:0]        en_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = cfg_we && (cfg_ch == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
        en_q[i]    <= '0;
      end else if (sel) begin
        start_q[i] <= cfg_start_word;
        end_q[i]   <= cfg_end_word;
        en_q[i]    <= cfg_dir_en;
      end
    end

    // R2
    other_ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_ch != CH_W'(i)) |=> ($stable(start_q[i]) && $stable(end_q[i]) && $stable(en_q[i])));
  end
endmodule

// File: rtl/dtq_range_cmp.sv
module dtq_range_cmp
  import dtq_pkg::*;
#(
  parameter int WA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] lo_word,
  input  logic [WA_W-1:0] hi_word,
  input  dir_en_t         dir_en,
  input  logic [WA_W-1:0] acc_word,
  input  logic            acc_write,
  output logic            hit,
  output logic            bad
);
  logic in_span, dir_ok;

  always_comb begin
    bad     = lo_word > hi_word;
    in_span = (acc_word >= lo_word) && (acc_word <= hi_word);
    dir_ok  = acc_write ? dir_en[DIR_WR_BIT] : dir_en[DIR_RD_BIT];
    hit     = !bad && in_span && dir_ok;
  end

  // R4
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_en == 2'b00) |-> !hit);
  // R7
  bad_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> !hit);
endmodule

// File: rtl/dtq_range_qual.sv
module dtq_range_qual
  import dtq_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WA_W  = ADDR_W - 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [WA_W-1:0]   cfg_start_word,
  input  logic [WA_W-1:0]   cfg_end_word,
  input  logic [1:0]        cfg_dir_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              trc_valid,
  output logic [ADDR_W-1:0] trc_addr,
  output logic [DATA_W-1:0] trc_data,
  output logic              trc_write,
  output logic [NCH-1:0]    trc_hit,
  output logic [NCH-1:0]    range_bad
);
  logic [NCH-1:0][WA_W-1:0] start_q, end_q;
  logic [NCH-1:0][1:0]      en_q;
  logic [NCH-1:0]           hit_now;
  logic                     qual_now;

  dtq_cfg_bank #(.NCH(NCH), .WA_W(WA_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_start_word(cfg_start_word), .cfg_end_word(cfg_end_word),
    .cfg_dir_en(cfg_dir_en), .start_q(start_q), .end_q(end_q), .en_q(en_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    dtq_range_cmp #(.WA_W(WA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .lo_word(start_q[i]), .hi_word(end_q[i]), .dir_en(en_q[i]),
      .acc_word(bus_addr[ADDR_W-1:2]), .acc_write(bus_write),
      .hit(hit_now[i]), .bad(range_bad[i])
    );
  end

  assign qual_now = bus_valid && (|hit_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc_valid <= 1'b0;
      trc_hit   <= '0;
      trc_addr  <= '0;
      trc_data  <= '0;
      trc_write <= 1'b0;
    end else begin
      trc_valid <= qual_now;
      trc_hit   <= qual_now ? hit_now : '0;
      if (qual_now) begin
        trc_addr  <= bus_addr;
        trc_data  <= bus_data;
        trc_write <= bus_write;
      end
    end
  end

  // R8
  valid_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid |-> (trc_hit != '0));
  // R9
  valid_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid |-> $past(bus_valid));
endmodule

// File: tb/sim_dtq_range_qual.sv
module sim_dtq_range_qual;
  localparam int NCH = 2, AW = 32, DW = 32, WA = AW - 2;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [0:0] cfg_ch = 0;
  logic [WA-1:0] cfg_s = 0, cfg_e = 0; logic [1:0] cfg_en = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = 0; logic [DW-1:0] bus_data = 0;
  logic trc_valid, trc_write; logic [AW-1:0] trc_addr; logic [DW-1:0] trc_data;
  logic [NCH-1:0] trc_hit, range_bad;

  always #5 clk = ~clk;

  dtq_range_qual u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_start_word(cfg_s), .cfg_end_word(cfg_e), .cfg_dir_en(cfg_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_data(bus_data),
    .trc_valid(trc_valid), .trc_addr(trc_addr), .trc_data(trc_data),
    .trc_write(trc_write), .trc_hit(trc_hit), .range_bad(range_bad)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  longint ms[NCH], me[NCH]; int men[NCH];
  bit e_valid, e_write; bit [NCH-1:0] e_hit, e_bad;
  bit [AW-1:0] e_addr; bit [DW-1:0] e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ms[i]) begin ms[i] = 0; me[i] = 0; men[i] = 0; end
      e_valid = 0; e_hit = 0; e_addr = 0; e_data = 0; e_write = 0;
    end else begin
      bit [NCH-1:0] h;
      longint w;
      w = longint'(bus_addr >> 2);
      h = 0;
      for (int i = 0; i < NCH; i++)
        if (ms[i] <= me[i] && w >= ms[i] && w <= me[i] &&
            ((bus_write && men[i][1]) || (!bus_write && men[i][0]))) h[i] = 1;
      e_valid = bus_valid && (h != 0);
      e_hit = e_valid ? h : '0;
      if (e_valid) begin e_addr = bus_addr; e_data = bus_data; e_write = bus_write; end
      if (cfg_we) begin ms[cfg_ch] = cfg_s; me[cfg_ch] = cfg_e; men[cfg_ch] = cfg_en; end
    end
    for (int i = 0; i < NCH; i++) e_bad[i] = ms[i] > me[i];
  end

  task automatic chk(input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cycles > 0) begin
    chk("trc_valid", trc_valid, e_valid);
    chk("trc_hit", trc_hit, e_hit);
    chk("range_bad", range_bad, e_bad);
    if (e_valid) begin
      chk("trc_addr", trc_addr, e_addr);
      chk("trc_data", trc_data, e_data);
      chk("trc_write", trc_write, e_write);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cfg(input int ch, input longint sbyte, input longint ebyte, input int en);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch[0:0]; cfg_s = WA'(sbyte >> 2); cfg_e = WA'(ebyte >> 2); cfg_en = en[1:0];
    bus_valid = 0;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic acc(input longint a, input bit wr);
    @(negedge clk);
    cfg_we = 0; bus_valid = 1; bus_write = wr; bus_addr = AW'(a); bus_data = $urandom;
    @(negedge clk); bus_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset trc_valid", trc_valid, 0);
    chk("reset range_bad", range_bad, 0);
    chk("reset trc_hit", trc_hit, 0);

    cur_req = "R2";
    @(negedge clk);
    cfg_we = 1; cfg_ch = 0; cfg_s = WA'(32'h1000 >> 2); cfg_e = WA'(32'h1010 >> 2); cfg_en = 2'b11;
    bus_valid = 1; bus_write = 0; bus_addr = 32'h1004; bus_data = 32'hA5A5;
    @(negedge clk); cfg_we = 0; bus_valid = 0;
    acc(32'h1004, 0);

    cur_req = "R5";
    foreach (ms[k]) begin end
    acc(32'h0FFC, 0); acc(32'h1000, 0); acc(32'h1008, 1);
    acc(32'h1010, 1); acc(32'h1014, 0); acc(32'h1013, 0);

    cur_req = "R3";
    cfg(1, 32'h2003, 32'h2003, 1);
    acc(32'h2001, 0); acc(32'h2003, 0);
    cur_req = "R6";
    acc(32'h2004, 0); acc(32'h1FFC, 0); acc(32'h2000, 0);

    cur_req = "R4";
    cfg(1, 32'h2000, 32'h2000, 0);
    acc(32'h2000, 0); acc(32'h2000, 1);
    cfg(1, 32'h2000, 32'h2000, 2);
    acc(32'h2000, 0); acc(32'h2000, 1);
    cfg(1, 32'h2000, 32'h2000, 1);
    acc(32'h2000, 1); acc(32'h2000, 0);

    cur_req = "R7";
    cfg(0, 32'h5000, 32'h4000, 3);
    acc(32'h4800, 0); acc(32'h5000, 1); acc(32'h4000, 0);

    cur_req = "R8";
    cfg(0, 32'h3000, 32'h3100, 3);
    cfg(1, 32'h3080, 32'h3200, 3);
    acc(32'h3090, 0); acc(32'h3010, 1); acc(32'h3180, 0); acc(32'h3300, 0);

    cur_req = "R10";
    cfg(0, 32'h2000, 32'h3FF0, 3);
    acc(32'h2000, 0); acc(32'h2ABC, 1); acc(32'h3FF0, 0); acc(32'h3FF4, 1);

    cur_req = "R9";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfg_we = ($urandom % 16) == 0;
      cfg_ch = 1'($urandom);
      cfg_s = WA'(($urandom % 64) + 32'h400);
      cfg_e = WA'(($urandom % 64) + 32'h400);
      cfg_en = 2'($urandom);
      bus_valid = 1'($urandom);
      bus_write = 1'($urandom);
      bus_addr = (($urandom % 80) + 32'h1000 - 32'h20) & 32'hFFFF_FFFF;
      bus_addr = {bus_addr[AW-1:2], 2'($urandom)};
      bus_data = $urandom;
    end
    @(negedge clk); cfg_we = 0; bus_valid = 0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule